// File: doc/BRIEF.md
# Packet Page Allocator and Queue Manager

This block keeps track of a small pool of fixed-size packet pages inside a network controller. A bitmap records which pages are taken. The host asks for a page through a command register and gets the lowest free page number back. The receive engine asks for pages with a one-cycle strobe. Three shift queues of page numbers carry frames between the host and the engines:
- a send queue, filled by host commands and drained by the transmit engine;
- a receive queue, filled by the receive engine and drained by host commands;
- a completion queue of sent pages that are waiting for the host to acknowledge them.

The host drives a small byte-wide write port with four registers: command, page select, interrupt acknowledge and interrupt mask. The command is taken from the top three bits of the command byte. When a host allocation fails, it remains pending. It completes on its own as soon as any page is given back. The block keeps four interrupt flags, combines them with the mask, and drives a single registered interrupt line. Packet data storage and the frame engines are outside this block.

When several events meet in one cycle, they resolve in a fixed order: page releases first, then the receive engine's allocation, then the host allocation or its retry.

Top module: `pkt_page_mgr`

## Requirements
- R1: Each allocation takes the lowest-numbered free page and marks it used. A host allocation that finds no free page returns 0x80. `free_pages` always shows the number of unused pages.
- R2: The register select values are 0 = command, 1 = page select, 2 = interrupt acknowledge and 3 = mask. Only bits [7:5] of a command byte select the command: 0 = none, 1 = allocate, 2 = reset the allocator, 3 = drop the receive head, 4 = free the receive head and drop it, 5 = free the selected page, 6 = append the selected page to the send queue, 7 = clear the send and completion queues.
- R3: An allocate command clears the allocation flag (status bit 3). The flag is set again only when a page is granted.
- R4: A release frees the page. If a host allocation is still pending, it is retried in the same cycle: `alloc_result` takes the new page and the allocation flag is set.
- R5: A `rx_push` strobe allocates the lowest free page and appends it to the receive queue. The strobe is ignored when no page is free. Dropping the head moves the later entries forward and does not free the page. The receive flag (bit 0) is set while the queue holds entries and is cleared when a drop leaves the queue empty.
- R6: The send-empty flag (bit 2) is forced on whenever the send queue is empty. The send-done flag (bit 1) is forced on whenever the completion queue holds entries.
- R7: A write to the acknowledge register clears the status bits selected by the written value AND 0xD6, so bits 0 and 3 are never cleared this way. Writing bit 1 also drops the completion queue head. Status bits [7:4] read as 0.
- R8: `irq` is high when the status flags AND the mask register are non-zero. It is updated one clock after the write or event that changes either of them.
- R9: Appending to a full send queue has no effect. An empty queue shows 0x80 (bit 7 set) at its head port.
- R10: After reset: status is 0x04, `free_pages` equals the page count, `alloc_result` and all queue heads are 0x80, the mask is 0, and `irq` is low.
- R11: A `tx_send` strobe removes the send queue head. With `tx_auto_release` high, that page is freed. Otherwise the page is appended to the completion queue. The strobe is ignored when the send queue is empty.
- R12: Command 2 frees every page and empties all three queues. Command 7 empties only the send and completion queues and leaves the page bitmap alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| rx_push | input | 1 | Receive engine requests a page for a new frame |
| tx_send | input | 1 | Transmit engine has sent the send queue head |
| tx_auto_release | input | 1 | Free the sent page instead of queueing it as completed |
| alloc_result | output | 8 | Last host allocation result, 0x80 on failure |
| free_pages | output | clog2(NPAGES+1) | Number of free pages |
| rx_ready | output | 1 | At least one page is free |
| tx_head | output | 8 | Send queue head, 0x80 when empty |
| tx_done_head | output | 8 | Completion queue head, 0x80 when empty |
| rx_head | output | 8 | Receive queue head, 0x80 when empty |
| irq_status | output | 8 | Interrupt flags |
| irq_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the pool, asks for one more page, and then frees a page from the middle. If the retry were lost, `alloc_result` would stay 0x80 and the freed page would be left idle. If the search were not lowest-first, a different page would come back after two holes are opened.

The bench offers a full send queue a fifth entry and then drains the queue. If the extra entry had been accepted, the head would still show a page after four sends. It pushes a receive frame into a full pool and drains that queue too. An acknowledge of 0xFF must leave the allocation and receive flags untouched. Acknowledging send-done while the completion queue still holds pages must leave the flag set, or the flag would drop while sent pages are still waiting.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ALLOC   = 3'd1,
    CMD_RESET   = 3'd2,
    CMD_RX_DROP = 3'd3,
    CMD_RX_FREE = 3'd4,
    CMD_RELEASE = 3'd5,
    CMD_TX_ADD  = 3'd6,
    CMD_TX_CLR  = 3'd7
  } mmu_cmd_e;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_PAGE = 2'd1,
    SEL_ACK  = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;

  localparam int FLG_RX    = 0;
  localparam int FLG_TXD   = 1;
  localparam int FLG_TXE   = 2;
  localparam int FLG_ALLOC = 3;

  localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [7:0] NO_PAGE       = 8'h80;

endpackage

// File: rtl/page_queue.sv
module page_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic [CW-1:0] count_nxt
);

  logic [W-1:0]  slot_q [DEPTH];
  logic [W-1:0]  slot_d [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;
  logic [CW-1:0] wr_idx;

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
    wr_idx  = cnt_q - CW'(do_pop);
    if (clr)
      count_nxt = '0;
    else
      count_nxt = cnt_q - CW'(do_pop) + CW'(do_push);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (do_pop)
      for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i+1];
    for (int i = 0; i < DEPTH; i++)
      if (do_push && (CW'(i) == wr_idx)) slot_d[i] = din;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= count_nxt;
  end

  assign head  = slot_q[0];
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/page_pool.sv
module page_pool #(
  parameter int NPAGES = 4,
  localparam int PW    = $clog2(NPAGES),
  localparam int CW    = $clog2(NPAGES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rel_a,
  input  logic [PW-1:0] rel_a_idx,
  input  logic          rel_b,
  input  logic [PW-1:0] rel_b_idx,
  input  logic          rx_req,
  input  logic          host_req,
  output logic          rx_grant,
  output logic [PW-1:0] rx_page,
  output logic          host_grant,
  output logic [PW-1:0] host_page,
  output logic [CW-1:0] free_cnt,
  output logic          all_used
);

  logic [NPAGES-1:0] used_q, used_d;
  logic [NPAGES-1:0] after_rel, after_rx, after_host;
  logic [CW-1:0]     free_d;

  function automatic logic [PW-1:0] lowest_clear(input logic [NPAGES-1:0] m);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPAGES - 1; i >= 0; i--)
      if (!m[i]) r = PW'(i);
    return r;
  endfunction

  function automatic logic [CW-1:0] count_clear(input logic [NPAGES-1:0] m);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NPAGES; i++)
      if (!m[i]) c = c + 1'b1;
    return c;
  endfunction

  always_comb begin
    after_rel = used_q;
    if (rel_a) after_rel[rel_a_idx] = 1'b0;
    if (rel_b) after_rel[rel_b_idx] = 1'b0;

    rx_page  = lowest_clear(after_rel);
    rx_grant = rx_req && !(&after_rel);
    after_rx = after_rel;
    if (rx_grant) after_rx[rx_page] = 1'b1;

    host_page  = lowest_clear(after_rx);
    host_grant = host_req && !(&after_rx);
    after_host = after_rx;
    if (host_grant) after_host[host_page] = 1'b1;

    used_d = clr ? '0 : after_host;
    free_d = count_clear(used_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q   <= '0;
      free_cnt <= CW'(NPAGES);
    end else begin
      used_q   <= used_d;
      free_cnt <= free_d;
    end
  end

  assign all_used = &used_q;

endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
  import pgm_pkg::*;
#(
  parameter int NPAGES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic [1:0]                   reg_addr,
  input  logic [7:0]                   reg_wdata,
  input  logic                         rx_push,
  input  logic                         tx_send,
  input  logic                         tx_auto_release,
  output logic [7:0]                   alloc_result,
  output logic [$clog2(NPAGES+1)-1:0]  free_pages,
  output logic                         rx_ready,
  output logic [7:0]                   tx_head,
  output logic [7:0]                   tx_done_head,
  output logic [7:0]                   rx_head,
  output logic [7:0]                   irq_status,
  output logic [7:0]                   irq_mask,
  output logic                         irq
);

  localparam int PW = $clog2(NPAGES);
  localparam int CW = $clog2(NPAGES + 1);

  // register decode
  logic     wr_cmd, wr_page, wr_ack, wr_mask;
  mmu_cmd_e cmd;
  logic     c_alloc, c_reset, c_rx_drop, c_rx_free, c_release, c_tx_add, c_tx_clr;

  assign wr_cmd  = reg_wr && (reg_addr == SEL_CMD);
  assign wr_page = reg_wr && (reg_addr == SEL_PAGE);
  assign wr_ack  = reg_wr && (reg_addr == SEL_ACK);
  assign wr_mask = reg_wr && (reg_addr == SEL_MASK);
  assign cmd     = mmu_cmd_e'(reg_wdata[7:5]);

  assign c_alloc   = wr_cmd && (cmd == CMD_ALLOC);
  assign c_reset   = wr_cmd && (cmd == CMD_RESET);
  assign c_rx_drop = wr_cmd && (cmd == CMD_RX_DROP);
  assign c_rx_free = wr_cmd && (cmd == CMD_RX_FREE);
  assign c_release = wr_cmd && (cmd == CMD_RELEASE);
  assign c_tx_add  = wr_cmd && (cmd == CMD_TX_ADD);
  assign c_tx_clr  = wr_cmd && (cmd == CMD_TX_CLR);

  // architectural registers
  logic [7:0] page_sel_q;
  logic [7:0] mask_q;
  logic [7:0] status_q, status_d;
  logic [7:0] result_q;
  logic       pend_q, pend_d;
  logic       irq_q;

  logic          page_ok;
  logic [PW-1:0] page_idx;
  assign page_ok  = (page_sel_q < 8'(NPAGES));
  assign page_idx = page_sel_q[PW-1:0];

  // queue wiring
  logic [PW-1:0] txq_head, rxq_head, dnq_head;
  logic          txq_empty, rxq_empty, dnq_empty;
  logic [CW-1:0] txq_cnt_nxt, rxq_cnt_nxt, dnq_cnt_nxt;
  logic          tx_go, rxq_pop, dnq_pop;

  // pool wiring
  logic          rel_a, rel_b;
  logic [PW-1:0] rel_b_idx;
  logic          host_req;
  logic          rx_grant, host_grant, all_used;
  logic [PW-1:0] rx_page, host_page;

  assign tx_go   = tx_send && !txq_empty;
  assign rel_a   = tx_go && tx_auto_release;
  assign rxq_pop = c_rx_drop || c_rx_free;
  assign dnq_pop = wr_ack && reg_wdata[FLG_TXD];

  always_comb begin
    rel_b     = 1'b0;
    rel_b_idx = page_idx;
    if (c_release && page_ok) begin
      rel_b = 1'b1;
    end else if (c_rx_free && !rxq_empty) begin
      rel_b     = 1'b1;
      rel_b_idx = rxq_head;
    end
  end

  assign host_req = c_alloc || (pend_q && (rel_a || rel_b));

  page_pool #(.NPAGES(NPAGES)) u_pool (
    .clk        (clk),
    .rst        (rst),
    .clr        (c_reset),
    .rel_a      (rel_a),
    .rel_a_idx  (txq_head),
    .rel_b      (rel_b),
    .rel_b_idx  (rel_b_idx),
    .rx_req     (rx_push),
    .host_req   (host_req),
    .rx_grant   (rx_grant),
    .rx_page    (rx_page),
    .host_grant (host_grant),
    .host_page  (host_page),
    .free_cnt   (free_pages),
    .all_used   (all_used)
  );

  page_queue #(.DEPTH(NPAGES), .W(PW)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .clr       (c_reset || c_tx_clr),
    .push      (c_tx_add && page_ok),
    .din       (page_idx),
    .pop       (tx_send),
    .head      (txq_head),
    .empty     (txq_empty),
    .count_nxt (txq_cnt_nxt)
  );

  page_queue #(.DEPTH(NPAGES), .W(PW)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .clr       (c_reset),
    .push      (rx_grant),
    .din       (rx_page),
    .pop       (rxq_pop),
    .head      (rxq_head),
    .empty     (rxq_empty),
    .count_nxt (rxq_cnt_nxt)
  );

  page_queue #(.DEPTH(NPAGES), .W(PW)) u_dnq (
    .clk       (clk),
    .rst       (rst),
    .clr       (c_reset || c_tx_clr),
    .push      (tx_go && !tx_auto_release),
    .din       (txq_head),
    .pop       (dnq_pop),
    .head      (dnq_head),
    .empty     (dnq_empty),
    .count_nxt (dnq_cnt_nxt)
  );

  // status flag update
  always_comb begin
    status_d = status_q;
    if (wr_ack)     status_d = status_d & ~(reg_wdata & ACK_CLEARABLE);
    if (c_alloc)    status_d[FLG_ALLOC] = 1'b0;
    if (host_grant) status_d[FLG_ALLOC] = 1'b1;
    if (rxq_pop || rx_grant) status_d[FLG_RX] = (rxq_cnt_nxt != '0);
    if (txq_cnt_nxt == '0)   status_d[FLG_TXE] = 1'b1;
    if (dnq_cnt_nxt != '0)   status_d[FLG_TXD] = 1'b1;
    status_d[7:4] = 4'b0;
  end

  always_comb begin
    pend_d = pend_q;
    if (c_reset)       pend_d = 1'b0;
    else if (host_req) pend_d = !host_grant;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_sel_q <= '0;
      mask_q     <= '0;
      status_q   <= 8'h00 | (8'h01 << FLG_TXE);
      result_q   <= NO_PAGE;
      pend_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_page) page_sel_q <= reg_wdata;
      if (wr_mask) mask_q     <= reg_wdata;
      if (host_req) result_q  <= host_grant ? 8'(host_page) : NO_PAGE;
      status_q <= status_d;
      pend_q   <= pend_d;
      irq_q    <= |(status_d & (wr_mask ? reg_wdata : mask_q));
    end
  end

  assign alloc_result = result_q;
  assign irq_status   = status_q;
  assign irq_mask     = mask_q;
  assign irq          = irq_q;
  assign rx_ready     = !all_used;
  assign tx_head      = txq_empty ? NO_PAGE : 8'(txq_head);
  assign rx_head      = rxq_empty ? NO_PAGE : 8'(rxq_head);
  assign tx_done_head = dnq_empty ? NO_PAGE : 8'(dnq_head);

endmodule

// File: rtl/pgm_checker.sv
module pgm_checker #(
  parameter int NPAGES = 4,
  localparam int CW    = $clog2(NPAGES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          pend,
  input logic [CW-1:0] free_pages,
  input logic [7:0]    tx_head,
  input logic [7:0]    tx_done_head,
  input logic [7:0]    rx_head,
  input logic [7:0]    irq_status,
  input logic [7:0]    irq_mask,
  input logic          irq
);

  assert_free_bound_R1: assert property (@(posedge clk) disable iff (rst)
    free_pages <= CW'(NPAGES));

  assert_pending_only_when_full_R4: assert property (@(posedge clk) disable iff (rst)
    pend |-> (free_pages == '0));

  assert_rx_flag_follows_queue_R5: assert property (@(posedge clk) disable iff (rst)
    !rx_head[7] |-> irq_status[0]);

  assert_tx_empty_forced_R6: assert property (@(posedge clk) disable iff (rst)
    tx_head[7] |-> irq_status[2]);

  assert_tx_done_forced_R6: assert property (@(posedge clk) disable iff (rst)
    !tx_done_head[7] |-> irq_status[1]);

  assert_upper_status_zero_R7: assert property (@(posedge clk) disable iff (rst)
    irq_status[7:4] == 4'b0);

  assert_irq_matches_mask_R8: assert property (@(posedge clk) disable iff (rst)
    irq == |(irq_status & irq_mask));

endmodule

bind pkt_page_mgr pgm_checker #(.NPAGES(NPAGES)) u_pgm_checker (
  .clk          (clk),
  .rst          (rst),
  .pend         (pend_q),
  .free_pages   (free_pages),
  .tx_head      (tx_head),
  .tx_done_head (tx_done_head),
  .rx_head      (rx_head),
  .irq_status   (irq_status),
  .irq_mask     (irq_mask),
  .irq          (irq)
);

// File: tb/pkt_page_mgr_tb_top.sv
module pkt_page_mgr_tb_top;

  localparam int NPAGES = 4;
  localparam int CW     = $clog2(NPAGES + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic          rx_push = 1'b0;
  logic          tx_send = 1'b0;
  logic          tx_auto_release = 1'b0;
  logic [7:0]    alloc_result;
  logic [CW-1:0] free_pages;
  logic          rx_ready;
  logic [7:0]    tx_head, tx_done_head, rx_head, irq_status, irq_mask;
  logic          irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  pkt_page_mgr #(.NPAGES(NPAGES)) dut_i (
    .clk             (clk),
    .rst             (rst),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .rx_push         (rx_push),
    .tx_send         (tx_send),
    .tx_auto_release (tx_auto_release),
    .alloc_result    (alloc_result),
    .free_pages      (free_pages),
    .rx_ready        (rx_ready),
    .tx_head         (tx_head),
    .tx_done_head    (tx_done_head),
    .rx_head         (rx_head),
    .irq_status      (irq_status),
    .irq_mask        (irq_mask),
    .irq             (irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rx_frame();
    @(negedge clk);
    rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic send(input logic auto_rel);
    @(negedge clk);
    tx_send = 1'b1; tx_auto_release = auto_rel;
    @(negedge clk);
    tx_send = 1'b0; tx_auto_release = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 status", irq_status, 8'h04);
    check("R10 free", free_pages, NPAGES);
    check("R10 alloc_result", alloc_result, 8'h80);
    check("R10 tx_head", tx_head, 8'h80);
    check("R10 rx_head", rx_head, 8'h80);
    check("R10 tx_done_head", tx_done_head, 8'h80);
    check("R10 irq", irq, 0);
    check("R10 mask", irq_mask, 0);
  endtask

  task automatic t_alloc();
    for (int i = 0; i < NPAGES; i++) begin
      wr(2'd0, 8'h20);
      check("R1 lowest grant", alloc_result, i);
      check("R3 alloc flag set", irq_status[3], 1);
    end
    check("R1 pool empty", free_pages, 0);
    check("R5 rx_ready low", rx_ready, 0);
    wr(2'd0, 8'h20);
    check("R1 fail code", alloc_result, 8'h80);
    check("R3 alloc flag cleared", irq_status[3], 0);
    wr(2'd1, 8'd2);
    wr(2'd0, 8'hA0);
    check("R4 retry result", alloc_result, 2);
    check("R4 retry flag", irq_status[3], 1);
    check("R4 retry free", free_pages, 0);
    wr(2'd1, 8'd3); wr(2'd0, 8'hA0);
    wr(2'd1, 8'd1); wr(2'd0, 8'hA0);
    check("R4 release frees", free_pages, 2);
    wr(2'd0, 8'h20);
    check("R1 lowest after holes", alloc_result, 1);
    wr(2'd0, 8'h40);
    check("R12 reset frees all", free_pages, NPAGES);
  endtask

  task automatic t_tx();
    wr(2'd0, 8'h20); wr(2'd0, 8'h20);
    wr(2'd1, 8'd0); wr(2'd0, 8'hC0);
    wr(2'd1, 8'd1); wr(2'd0, 8'hC0);
    check("R11 tx head", tx_head, 0);
    wr(2'd2, 8'hFF);
    check("R7 ack FF keeps bits 0 and 3", irq_status, 8'h08);
    send(1'b0);
    check("R11 head advances", tx_head, 1);
    check("R11 done head", tx_done_head, 0);
    check("R6 done flag", irq_status[1], 1);
    send(1'b0);
    check("R6 empty flag forced", irq_status[2], 1);
    check("R11 no release", free_pages, 2);
    wr(2'd2, 8'h02);
    check("R7 ack pops done", tx_done_head, 1);
    check("R7 done flag held", irq_status[1], 1);
    wr(2'd2, 8'h02);
    check("R7 done empty", tx_done_head, 8'h80);
    check("R7 done flag cleared", irq_status[1], 0);
    wr(2'd1, 8'd0); wr(2'd0, 8'hC0);
    send(1'b1);
    check("R11 auto release", free_pages, 3);
    check("R11 auto no done", tx_done_head, 8'h80);
    wr(2'd1, 8'd1); wr(2'd0, 8'hC0);
    send(1'b0);
    wr(2'd0, 8'hC0);
    check("R12 pre clear head", tx_head, 1);
    wr(2'd0, 8'hE0);
    check("R12 cmd7 tx", tx_head, 8'h80);
    check("R12 cmd7 done", tx_done_head, 8'h80);
    check("R12 cmd7 keeps pages", free_pages, 3);
    wr(2'd0, 8'h40);
  endtask

  task automatic t_txfull();
    wr(2'd1, 8'd0);
    for (int i = 0; i < NPAGES + 1; i++) wr(2'd0, 8'hC0);
    for (int i = 0; i < NPAGES; i++) send(1'b0);
    check("R9 full append ignored", tx_head, 8'h80);
    wr(2'd0, 8'h40);
    check("R9 empty done head", tx_done_head, 8'h80);
  endtask

  task automatic t_rx();
    rx_frame();
    check("R5 rx head", rx_head, 0);
    check("R5 rx flag", irq_status[0], 1);
    rx_frame();
    check("R5 rx free", free_pages, 2);
    wr(2'd0, 8'h60);
    check("R5 drop shifts", rx_head, 1);
    check("R5 drop keeps flag", irq_status[0], 1);
    check("R5 drop keeps page", free_pages, 2);
    wr(2'd0, 8'h80);
    check("R5 free-drop empty", rx_head, 8'h80);
    check("R5 flag cleared", irq_status[0], 0);
    check("R5 free-drop frees", free_pages, 3);
    for (int i = 0; i < NPAGES; i++) rx_frame();
    check("R5 pool full", free_pages, 0);
    wr(2'd0, 8'h80);
    check("R5 head 2", rx_head, 2);
    wr(2'd0, 8'h80); wr(2'd0, 8'h80);
    check("R5 extra push ignored", rx_head, 8'h80);
    wr(2'd0, 8'h3F);
    check("R2 low bits ignored", alloc_result, 1);
    wr(2'd0, 8'h1F);
    check("R2 nop", free_pages, 2);
  endtask

  task automatic t_irq();
    wr(2'd3, 8'h01);
    check("R8 masked off", irq, 0);
    rx_frame();
    check("R8 rx irq", irq, 1);
    wr(2'd3, 8'h00);
    check("R8 mask zero", irq, 0);
    wr(2'd3, 8'h04);
    check("R8 txe irq", irq, 1);
    check("R8 mask readback", irq_mask, 8'h04);
  endtask

  initial begin
    #(20 * 100000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_alloc();
    t_tx();
    t_txfull();
    t_rx();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule